// File: doc/BRIEF.md
# Timer Compare Channel with PWM Reference

This block is one compare channel of a general-purpose timer. Each cycle it sees the timer's counter value, the count direction, a one-cycle counter tick and the compare value for the channel. From these it keeps an active-high reference waveform, and it drives a true output and a complementary output from that waveform. Each output has its own polarity bit.

The reference follows one of eight compare modes held in a 3-bit mode register:
- 0: frozen.
- 1: set on match.
- 2: clear on match.
- 3: toggle on match.
- 4: force low.
- 5: force high.
- 6: PWM, first polarity.
- 7: PWM, second polarity.

Mode writes can be double-buffered. With preload on, a written mode waits in a shadow register until a commutation pulse copies it into the active register. A full-lock input blocks mode writes while the channel is an output. A 2-bit direction select turns the channel into an input. That select can only be written while the channel enable is low.

In the PWM modes the reference follows the compare result, but only at the moments that result changes, or on the first cycle after leaving the frozen mode. A mode change alone does not move the reference. The block is used next to a counter. Software-style writes arrive as single-cycle strobes with data.

Top module: `cmp_chan`

## Requirements
- R1: After a synchronous active-low reset:
  - the reference is 0;
  - the active mode is 0 (frozen);
  - the direction select is 0 (output).
- R2: In mode 0 a counter/compare match, with or without a tick, leaves the reference unchanged.
- R3: Mode 1 sets the reference to 1, and mode 2 clears it to 0, on the clock edge of a tick where the counter equals the compare value. A tick without equality changes nothing.
- R4: Mode 3 inverts the reference on each tick where the counter equals the compare value. Equality without a tick has no effect.
- R5: Mode 4 drives the reference to 0, and mode 5 drives it to 1, one cycle after the mode is active, without needing a tick.
- R6: Mode 6 reference level:
  - Counting up (count_down=0), the level is 1 while counter < compare, else 0.
  - Counting down (count_down=1), the level is 0 while counter > compare, else 1.
- R7: Mode 7 produces the inverse of the mode 6 level in both count directions.
- R8: In modes 6 and 7 the reference is updated only in two cases:
  - on a tick where the raw compare result differs from its value at the previous tick;
  - on the first cycle after the active mode was 0, when it takes the PWM level at once.

  Switching from a non-frozen mode into PWM leaves the reference where it was.
- R9: The true output is reference XOR pol_true. The complementary output is (NOT reference) XOR pol_comp. A polarity bit of 1 makes that output active low.
- R10: Mode writes with preload on:
  - With preload_on=1, a mode write only loads the shadow register. The active mode takes the shadow value on the edge of a com_pulse cycle.
  - With preload_on=0, a mode write changes the active mode on the next edge.
- R11: A mode write is ignored while lock_full=1 and the direction select is 0. It is accepted under lock when the direction select is non-zero.
- R12: Direction select behaviour:
  - Writes to the direction select are ignored while chan_en=1.
  - While the select is non-zero (1 own pin, 2 neighbour pin, 3 internal trigger), the reference is held at 0 and compare actions are suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Counter advanced this cycle |
| cnt_val | input | CW | Current counter value |
| count_down | input | 1 | 1 when the counter counts down |
| cmp_val | input | CW | Compare value |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode write data |
| sel_wr | input | 1 | Direction select write strobe |
| sel_wdata | input | 2 | Direction select write data |
| preload_on | input | 1 | Mode writes go to the shadow register |
| com_pulse | input | 1 | Commutation event: shadow to active |
| lock_full | input | 1 | Highest lock level programmed |
| chan_en | input | 1 | Channel enable |
| pol_true | input | 1 | True output polarity (1 = active low) |
| pol_comp | input | 1 | Complementary output polarity (1 = active low) |
| ref_o | output | 1 | Active-high reference waveform |
| out_true | output | 1 | True output |
| out_comp | output | 1 | Complementary output |
| mode_now | output | 3 | Active mode |
| sel_now | output | 2 | Current direction select |

## Verification
The assertions check the following on every cycle:
- the forced levels and the frozen hold;
- the held-low reference while the channel is an input;
- the stability of the select while the channel is enabled;
- the stability of the active mode while preload waits for a commutation pulse;
- the stability of the shadow register under full lock.

The bench scenarios are needed for the order-dependent behaviour:
- set, clear and toggle on the exact match tick;
- the PWM levels in both directions;
- the rule that a PWM entry from a non-frozen mode does not move the reference, while an entry from frozen does;
- the polarity of both outputs.

// File: rtl/cmp_chan_pkg.sv
// Shared types for the compare channel.
package cmp_chan_pkg;
    typedef enum logic [2:0] {
        M_FROZEN = 3'd0,
        M_SET    = 3'd1,
        M_CLR    = 3'd2,
        M_TGL    = 3'd3,
        M_LOW    = 3'd4,
        M_HIGH   = 3'd5,
        M_PWM1   = 3'd6,
        M_PWM2   = 3'd7
    } oc_mode_e;
endpackage

// File: rtl/cmp_chan_cfg.sv
// Configuration registers: shadow and active mode, direction select.
// Assumes single-cycle write strobes. A commutation pulse is honoured only
// when preload is on. Under full lock, output-channel mode writes are dropped.
module cmp_chan_cfg
    import cmp_chan_pkg::*;
#(
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic [2:0]    mode_wdata,
    input  logic          sel_wr,
    input  logic [SW-1:0] sel_wdata,
    input  logic          preload_on,
    input  logic          com_pulse,
    input  logic          lock_full,
    input  logic          chan_en,
    output oc_mode_e      mode_act,
    output logic [SW-1:0] sel_q
);
    oc_mode_e mode_shd;
    logic     mode_ok;

    // Decide whether a mode write is allowed under the lock rule.
    always_comb mode_ok = mode_wr && !(lock_full && (sel_q == '0));

    // Update the shadow and active mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_shd <= M_FROZEN;
            mode_act <= M_FROZEN;
        end else begin
            if (mode_ok) begin
                mode_shd <= oc_mode_e'(mode_wdata);
            end
            if (preload_on) begin
                if (com_pulse) begin
                    mode_act <= mode_shd;
                end
            end else if (mode_ok) begin
                mode_act <= oc_mode_e'(mode_wdata);
            end
        end
    end

    // Update the direction select only while the channel is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_wr && !chan_en) begin
            sel_q <= sel_wdata;
        end
    end

    // R12: select holds while the channel is enabled
    p_sel_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(sel_q));

    // R10: active mode waits for the commutation pulse
    p_preload_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_on && !com_pulse) |=> $stable(mode_act));

    // R11: locked output channel keeps its shadow mode
    p_lock_shadow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_full && sel_q == '0) |=> $stable(mode_shd));
endmodule

// File: rtl/cmp_chan_ref.sv
// Reference waveform generator: applies the active compare mode to the counter.
// Assumes the counter moves only on tick cycles. The raw compare result is
// sampled at each tick so that PWM updates follow result changes only.
module cmp_chan_ref
    import cmp_chan_pkg::*;
#(
    parameter int CW = 16,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] cnt_val,
    input  logic          count_down,
    input  logic [CW-1:0] cmp_val,
    input  oc_mode_e      mode_act,
    input  logic [SW-1:0] sel_q,
    output logic          ref_q
);
    logic     raw, raw_q, hit, pwm_lvl, ref_nxt;
    oc_mode_e mode_q;

    // Raw compare result and equality.
    always_comb begin
        raw     = count_down ? (cnt_val <= cmp_val) : (cnt_val < cmp_val);
        hit     = (cnt_val == cmp_val);
        pwm_lvl = (mode_act == M_PWM2) ? ~raw : raw;
    end

    // Next reference level from the active mode.
    always_comb begin
        ref_nxt = ref_q;
        if (sel_q != '0) begin
            ref_nxt = 1'b0;
        end else begin
            case (mode_act)
                M_SET:   if (tick && hit) ref_nxt = 1'b1;
                M_CLR:   if (tick && hit) ref_nxt = 1'b0;
                M_TGL:   if (tick && hit) ref_nxt = ~ref_q;
                M_LOW:   ref_nxt = 1'b0;
                M_HIGH:  ref_nxt = 1'b1;
                M_PWM1,
                M_PWM2:  if ((mode_q == M_FROZEN) || (tick && (raw != raw_q)))
                             ref_nxt = pwm_lvl;
                default: ref_nxt = ref_q;
            endcase
        end
    end

    // Register the reference, previous mode and last ticked compare result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= 1'b0;
            raw_q  <= 1'b0;
            mode_q <= M_FROZEN;
        end else begin
            ref_q  <= ref_nxt;
            mode_q <= mode_act;
            if (tick) begin
                raw_q <= raw;
            end
        end
    end

    // R2: frozen mode holds the reference
    p_frozen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act == M_FROZEN && sel_q == '0) |=> $stable(ref_q));

    // R5: forced low
    p_force_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act == M_LOW && sel_q == '0) |=> !ref_q);

    // R5: forced high
    p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act == M_HIGH && sel_q == '0) |=> ref_q);

    // R12: input channel keeps the reference low
    p_input_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != '0) |=> !ref_q);
endmodule

// File: rtl/cmp_chan_pol.sv
// Output polarity stage: even outputs follow the reference, odd outputs the
// inverted reference, each XORed with its own polarity bit.
// Purely combinational.
module cmp_chan_pol #(
    parameter int NOUT = 2
) (
    input  logic            ref_i,
    input  logic [NOUT-1:0] pol_i,
    output logic [NOUT-1:0] pin_o
);
    for (genvar i = 0; i < NOUT; i++) begin : g_pin
        if ((i % 2) == 0) begin : g_true
            assign pin_o[i] = ref_i ^ pol_i[i];
        end else begin : g_comp
            assign pin_o[i] = ~ref_i ^ pol_i[i];
        end
    end
endmodule

// File: rtl/cmp_chan.sv
// Top of one timer compare channel.
// Ties the configuration registers, the reference generator and the output
// polarity stage together. The counter is external.
module cmp_chan
    import cmp_chan_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] cnt_val,
    input  logic          count_down,
    input  logic [CW-1:0] cmp_val,
    input  logic          mode_wr,
    input  logic [2:0]    mode_wdata,
    input  logic          sel_wr,
    input  logic [1:0]    sel_wdata,
    input  logic          preload_on,
    input  logic          com_pulse,
    input  logic          lock_full,
    input  logic          chan_en,
    input  logic          pol_true,
    input  logic          pol_comp,
    output logic          ref_o,
    output logic          out_true,
    output logic          out_comp,
    output logic [2:0]    mode_now,
    output logic [1:0]    sel_now
);
    localparam int SW   = 2;
    localparam int NOUT = 2;

    oc_mode_e        mode_act;
    logic [SW-1:0]   sel_q;
    logic            ref_q;
    logic [NOUT-1:0] pins;

    cmp_chan_cfg #(.SW(SW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .preload_on(preload_on), .com_pulse(com_pulse),
        .lock_full(lock_full), .chan_en(chan_en),
        .mode_act(mode_act), .sel_q(sel_q)
    );

    cmp_chan_ref #(.CW(CW), .SW(SW)) u_ref (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_val(cnt_val), .count_down(count_down), .cmp_val(cmp_val),
        .mode_act(mode_act), .sel_q(sel_q), .ref_q(ref_q)
    );

    cmp_chan_pol #(.NOUT(NOUT)) u_pol (
        .ref_i(ref_q), .pol_i({pol_comp, pol_true}), .pin_o(pins)
    );

    assign ref_o    = ref_q;
    assign out_true = pins[0];
    assign out_comp = pins[1];
    assign mode_now = mode_act;
    assign sel_now  = sel_q;
endmodule

// File: tb/cmp_chan_test.sv
`timescale 1ns/1ps
module cmp_chan_test;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0, count_down = 1'b0;
    logic [CW-1:0] cnt_val = '0, cmp_val = 16'd100;
    logic          mode_wr = 1'b0, sel_wr = 1'b0;
    logic [2:0]    mode_wdata = '0;
    logic [1:0]    sel_wdata = '0;
    logic          preload_on = 1'b0, com_pulse = 1'b0, lock_full = 1'b0;
    logic          chan_en = 1'b0, pol_true = 1'b0, pol_comp = 1'b0;
    logic          ref_o, out_true, out_comp;
    logic [2:0]    mode_now;
    logic [1:0]    sel_now;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic       r, ot, oc;
        logic [2:0] m;
        logic [1:0] s;
        string      tag;
    } exp_t;
    exp_t sb[$];

    cmp_chan #(.CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val),
        .count_down(count_down), .cmp_val(cmp_val),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .preload_on(preload_on), .com_pulse(com_pulse),
        .lock_full(lock_full), .chan_en(chan_en),
        .pol_true(pol_true), .pol_comp(pol_comp),
        .ref_o(ref_o), .out_true(out_true), .out_comp(out_comp),
        .mode_now(mode_now), .sel_now(sel_now)
    );

    always #10 clk = ~clk;

    // Driver: push what must appear after the coming edge, then clear strobes.
    task automatic cyc(input logic er, input logic [2:0] em,
                       input logic [1:0] es, input string tag);
        exp_t e;
        e.r = er; e.ot = er ^ pol_true; e.oc = ~er ^ pol_comp;
        e.m = em; e.s = es; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; mode_wr = 1'b0; sel_wr = 1'b0; com_pulse = 1'b0;
    endtask

    task automatic tk(input logic [CW-1:0] c);
        tick = 1'b1; cnt_val = c;
    endtask

    task automatic wm(input logic [2:0] m);
        mode_wr = 1'b1; mode_wdata = m;
    endtask

    task automatic ws(input logic [1:0] s);
        sel_wr = 1'b1; sel_wdata = s;
    endtask

    // Monitor: compare each expected item just after its edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (ref_o !== e.r || out_true !== e.ot || out_comp !== e.oc ||
                    mode_now !== e.m || sel_now !== e.s) begin
                    errors++;
                    $display("FAIL %s: ref/out/outn/mode/sel got %b %b %b %0d %0d exp %b %b %b %0d %0d",
                             e.tag, ref_o, out_true, out_comp, mode_now, sel_now,
                             e.r, e.ot, e.oc, e.m, e.s);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, "R1 reset state");
        // Frozen mode.
        tk(100); cyc(0, 0, 0, "R2 frozen match");
        tk(50);  cyc(0, 0, 0, "R2 frozen no match");
        // Set and clear.
        wm(1);    cyc(0, 1, 0, "R3 mode set written");
        tk(99);   cyc(0, 1, 0, "R3 set no match");
        tk(100);  cyc(1, 1, 0, "R3 set on match");
        tk(100);  cyc(1, 1, 0, "R3 set stays");
        wm(2);    cyc(1, 2, 0, "R3 mode clear written");
        tk(100);  cyc(0, 2, 0, "R3 clear on match");
        // Toggle.
        wm(3);    cyc(0, 3, 0, "R4 mode toggle written");
        tk(100);  cyc(1, 3, 0, "R4 toggle up");
        tk(100);  cyc(0, 3, 0, "R4 toggle down");
        tk(101);  cyc(0, 3, 0, "R4 toggle no match");
        cnt_val = 100; cyc(0, 3, 0, "R4 match without tick");
        // Forced levels.
        wm(5);    cyc(0, 5, 0, "R5 force high written");
        cyc(1, 5, 0, "R5 forced high");
        wm(4);    cyc(1, 4, 0, "R5 force low written");
        cyc(0, 4, 0, "R5 forced low");
        wm(5);    cyc(0, 5, 0, "R5 force high again");
        cyc(1, 5, 0, "R5 forced high again");
        // PWM entry from a non-frozen mode, then PWM1 levels.
        cnt_val = 101; wm(6); cyc(1, 6, 0, "R8 pwm1 written from high");
        tk(101);  cyc(1, 6, 0, "R8 no result change keeps ref");
        tk(50);   cyc(1, 6, 0, "R6 up below compare");
        tk(100);  cyc(0, 6, 0, "R6 up at compare");
        tk(120);  cyc(0, 6, 0, "R6 up above compare");
        tk(99);   cyc(1, 6, 0, "R6 up below again");
        count_down = 1'b1;
        tk(99);   cyc(1, 6, 0, "R6 down below compare");
        tk(101);  cyc(0, 6, 0, "R6 down above compare");
        tk(100);  cyc(1, 6, 0, "R6 down at compare");
        // Entry from frozen.
        wm(0);    cyc(1, 0, 0, "R8 frozen written");
        tk(101);  cyc(1, 0, 0, "R2 frozen holds in pwm region");
        wm(6);    cyc(1, 6, 0, "R8 pwm1 written from frozen");
        cyc(0, 6, 0, "R8 frozen to pwm takes level");
        // PWM2.
        wm(7);    cyc(0, 7, 0, "R7 pwm2 written");
        tk(100);  cyc(0, 7, 0, "R7 down at compare");
        tk(105);  cyc(1, 7, 0, "R7 down above compare");
        count_down = 1'b0;
        tk(50);   cyc(0, 7, 0, "R7 up below compare");
        tk(100);  cyc(1, 7, 0, "R7 up at compare");
        // Polarity.
        pol_true = 1'b1; pol_comp = 1'b1;
        cyc(1, 7, 0, "R9 both active low");
        pol_true = 1'b0;
        cyc(1, 7, 0, "R9 mixed polarity");
        pol_comp = 1'b0;
        // Preload and commutation.
        preload_on = 1'b1;
        wm(4);    cyc(1, 7, 0, "R10 preloaded write held");
        cyc(1, 7, 0, "R10 still held");
        com_pulse = 1'b1; cyc(1, 4, 0, "R10 commutation transfer");
        cyc(0, 4, 0, "R10 new mode acts");
        preload_on = 1'b0;
        // Lock.
        lock_full = 1'b1;
        wm(5);    cyc(0, 4, 0, "R11 locked write ignored");
        cyc(0, 4, 0, "R11 locked mode unchanged");
        // Direction select.
        chan_en = 1'b1;
        ws(1);    cyc(0, 4, 0, "R12 select write while enabled");
        chan_en = 1'b0; lock_full = 1'b0;
        wm(5);    cyc(0, 5, 0, "R11 unlocked write accepted");
        cyc(1, 5, 0, "R5 forced high before input");
        ws(2);    cyc(1, 5, 2, "R12 select written");
        cyc(0, 5, 2, "R12 input holds ref low");
        lock_full = 1'b1;
        wm(3);    cyc(0, 3, 2, "R11 lock bypass on input");
        tk(100);  cyc(0, 3, 2, "R12 match suppressed on input");
        ws(0);    cyc(0, 3, 0, "R12 back to output");
        tk(100);  cyc(1, 3, 0, "R4 toggle after select cleared");
        @(posedge clk);
        #2;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: got %0d left exp 0", sb.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule